// File: doc/BRIEF.md
# Page Flush Recovery Engine

This block sits beside a core's private cache and runs when a page that one core has held privately must become shared. It takes a recovery request carrying a page number and the ID of the requesting node. It locks that page's translation entry, walks every block of the page in the local cache, writes dirty blocks back and evicts all present blocks. It then clears the private attribute, unlocks the entry and issues a completion message addressed to the requester.

The cache tags, the miss-status holding registers (MSHR) and the translation buffer are reached through simple ports. One lookup address drives both the cache probe and the MSHR query, which answer in the same cycle. The cache returns hit and dirty. The MSHR reports a pending miss or a pending eviction for the block. Writebacks use a valid/ready handshake and go to the block currently being looked up. A single strobe invalidates that block.

Top module: `page_flush_engine`

## Requirements
- R1: While reset is asserted, and after it is released, the engine is idle: `req_ready` is 1 and `look_valid`, `wb_valid`, `inv_en`, `tlb_we` and `cmpl_valid` are 0. A reset asserted in the middle of a recovery returns it to idle at once.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` both 1 at a clock edge), the engine writes the translation entry of the requested page with lock=1 and private=1. In that cycle it issues no lookup, writeback or invalidate.
- R3: Lookups start at block 0 in the cycle after the lock write. They move up by one block index at a time and advance at most one block per cycle. A block that causes no stall takes exactly one cycle.
- R4: A block whose probe reports a miss (`look_hit`=0) is skipped in one cycle, with no writeback and no invalidate, whatever the MSHR reports.
- R5: A present, clean block with nothing pending is invalidated in its lookup cycle without a writeback.
- R6: A present, dirty block with nothing pending raises `wb_valid`. Its invalidate is issued in the same cycle the writeback is accepted (`wb_ready`=1), and the scan moves on in that cycle.
- R7: While a present block has a pending miss or a pending eviction in the MSHR, the scan stays on that block with no writeback and no invalidate. Each such cycle adds one cycle to the recovery.
- R8: After the last block is handled, one further cycle writes the entry with lock=0 and private=0 and pulses `cmpl_valid`, with `cmpl_page` and `cmpl_dst` equal to the request's page and requester. The engine is idle in the next cycle.
- R9: From acceptance until the completion cycle, `req_ready` is 0. A request presented during that time is ignored and has no effect on the recovery in progress or afterwards.
- R10: Once `wb_valid` is raised, it stays at 1 on the same block until `wb_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Recovery request present |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_page | input | PAGE_W | Page to recover |
| req_src | input | NODE_W | ID of the requesting node |
| cmpl_valid | output | 1 | Completion message strobe (one cycle) |
| cmpl_page | output | PAGE_W | Page whose recovery has finished |
| cmpl_dst | output | NODE_W | Node the completion is addressed to |
| tlb_we | output | 1 | Translation attribute write strobe |
| tlb_page | output | PAGE_W | Page whose attributes are written |
| tlb_lock | output | 1 | Lock attribute value written |
| tlb_priv | output | 1 | Private attribute value written |
| look_valid | output | 1 | Cache probe and MSHR query active |
| look_page | output | PAGE_W | Page of the block being looked up |
| look_blk | output | $clog2(BLOCKS) | Block index within the page |
| look_hit | input | 1 | Block present in the cache |
| look_dirty | input | 1 | Present block is dirty |
| mshr_miss_pend | input | 1 | Miss outstanding for the looked-up block |
| mshr_evict_pend | input | 1 | Eviction outstanding for the looked-up block |
| wb_valid | output | 1 | Writeback of the looked-up block requested |
| wb_ready | input | 1 | Writeback accepted |
| inv_en | output | 1 | Invalidate the looked-up block |

## Verification
The bench builds the engine with 8 blocks per page, a 12-bit page number and 4-bit node IDs. A whole scan is short, so the last-block exit, the lowest and highest page numbers and pages that are empty, fully clean, fully dirty or mixed can all be covered with exact cycle counts. The small block count also keeps a block stalled by the MSHR and a block stalled by a slow writeback side by side in one short run. A second request is offered during a long run, and reset is applied in the middle of a scan.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOCK = 2'd1,
    ST_SCAN = 2'd2,
    ST_DONE = 2'd3
  } pfe_state_e;

endpackage

// File: rtl/pfe_blk_step.sv
module pfe_blk_step (
  input  logic active,
  input  logic hit,
  input  logic dirty,
  input  logic miss_pend,
  input  logic evict_pend,
  input  logic wb_ready,
  output logic advance,
  output logic wb_req,
  output logic inv
);

  logic pend;

  always_comb begin
    pend    = miss_pend | evict_pend;
    advance = 1'b0;
    wb_req  = 1'b0;
    inv     = 1'b0;
    if (active) begin
      if (!hit) begin
        advance = 1'b1;
      end else if (pend) begin
        advance = 1'b0;
      end else if (dirty) begin
        wb_req  = 1'b1;
        inv     = wb_ready;
        advance = wb_ready;
      end else begin
        inv     = 1'b1;
        advance = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pfe_blk_cnt.sv
module pfe_blk_cnt #(
  parameter int BLOCKS = 64,
  localparam int IDX_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(BLOCKS - 1);

  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = clr | step;
    idx_d  = clr ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_en) begin
      idx <= idx_d;
    end
  end

  assign at_last = (idx == LAST);

endmodule

// File: rtl/pfe_fsm.sv
module pfe_fsm
  import pfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       scan_adv,
  input  logic       at_last,
  output pfe_state_e state
);

  pfe_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (req_fire) state_d = ST_LOCK;
      ST_LOCK: state_d = ST_SCAN;
      ST_SCAN: if (scan_adv && at_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_d;
    end
  end

endmodule

// File: rtl/page_flush_engine.sv
module page_flush_engine
  import pfe_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int NODE_W = 6,
  parameter int BLOCKS = 64,
  localparam int IDX_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [NODE_W-1:0] req_src,
  output logic              cmpl_valid,
  output logic [PAGE_W-1:0] cmpl_page,
  output logic [NODE_W-1:0] cmpl_dst,
  output logic              tlb_we,
  output logic [PAGE_W-1:0] tlb_page,
  output logic              tlb_lock,
  output logic              tlb_priv,
  output logic              look_valid,
  output logic [PAGE_W-1:0] look_page,
  output logic [IDX_W-1:0]  look_blk,
  input  logic              look_hit,
  input  logic              look_dirty,
  input  logic              mshr_miss_pend,
  input  logic              mshr_evict_pend,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic              inv_en
);

  pfe_state_e        state;
  logic              req_fire;
  logic              scan_adv;
  logic              at_last;
  logic              scanning;
  logic [PAGE_W-1:0] page_q;
  logic [NODE_W-1:0] src_q;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid & req_ready;
  assign scanning  = (state == ST_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      src_q  <= '0;
    end else if (req_fire) begin
      page_q <= req_page;
      src_q  <= req_src;
    end
  end

  pfe_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .scan_adv (scan_adv),
    .at_last  (at_last),
    .state    (state)
  );

  pfe_blk_cnt #(.BLOCKS(BLOCKS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state == ST_LOCK),
    .step    (scan_adv),
    .idx     (look_blk),
    .at_last (at_last)
  );

  pfe_blk_step u_step (
    .active     (scanning),
    .hit        (look_hit),
    .dirty      (look_dirty),
    .miss_pend  (mshr_miss_pend),
    .evict_pend (mshr_evict_pend),
    .wb_ready   (wb_ready),
    .advance    (scan_adv),
    .wb_req     (wb_valid),
    .inv        (inv_en)
  );

  assign look_valid = scanning;
  assign look_page  = page_q;

  always_comb begin
    tlb_we   = (state == ST_LOCK) | (state == ST_DONE);
    tlb_page = page_q;
    tlb_lock = (state == ST_LOCK);
    tlb_priv = (state == ST_LOCK);
  end

  assign cmpl_valid = (state == ST_DONE);
  assign cmpl_page  = page_q;
  assign cmpl_dst   = src_q;

endmodule

// File: rtl/page_flush_engine_chk.sv
module page_flush_engine_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cmpl_valid,
  input logic             tlb_we,
  input logic             tlb_lock,
  input logic             tlb_priv,
  input logic             look_valid,
  input logic [IDX_W-1:0] look_blk,
  input logic             look_hit,
  input logic             look_dirty,
  input logic             mshr_miss_pend,
  input logic             mshr_evict_pend,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic             inv_en
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> req_ready && !look_valid && !tlb_we); // R1
  AST_LOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> tlb_we && tlb_lock && tlb_priv && !look_valid); // R2
  AST_SCAN_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(look_valid) |-> look_blk == '0); // R3
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid && $past(look_valid) |->
      (look_blk == $past(look_blk)) || (look_blk == $past(look_blk) + 1'b1)); // R3
  AST_MISS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid && !look_hit |-> !wb_valid && !inv_en); // R4
  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && !look_dirty |-> !wb_valid); // R5
  AST_DIRTY_INV: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && look_dirty |-> wb_valid && wb_ready); // R6
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid && (mshr_miss_pend || mshr_evict_pend) |-> !inv_en && !wb_valid); // R7
  AST_CMPL_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |-> tlb_we && !tlb_lock && !tlb_priv && $past(look_valid)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid || cmpl_valid |-> !req_ready); // R9
  AST_WB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(look_blk)); // R10

endmodule

bind page_flush_engine page_flush_engine_chk #(.IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .cmpl_valid      (cmpl_valid),
  .tlb_we          (tlb_we),
  .tlb_lock        (tlb_lock),
  .tlb_priv        (tlb_priv),
  .look_valid      (look_valid),
  .look_blk        (look_blk),
  .look_hit        (look_hit),
  .look_dirty      (look_dirty),
  .mshr_miss_pend  (mshr_miss_pend),
  .mshr_evict_pend (mshr_evict_pend),
  .wb_valid        (wb_valid),
  .wb_ready        (wb_ready),
  .inv_en          (inv_en)
);

// File: tb/test_page_flush_engine.sv
`timescale 1ns/1ps
module test_page_flush_engine;

  localparam int PW = 12;
  localparam int IW = 4;
  localparam int NB = 8;
  localparam int XW = 3;

  // {page[12], src[4], hit[8], dirty[8], pend[16] (2 bits per block), wb wait[2]}
  localparam int NV = 5;
  localparam logic [49:0] VEC [NV] = '{
    {12'h123, 4'h1, 8'h00, 8'h00, 16'h0000, 2'd0},
    {12'h000, 4'h2, 8'hFF, 8'h00, 16'h0000, 2'd0},
    {12'h456, 4'h3, 8'hFF, 8'hFF, 16'h0000, 2'd2},
    {12'h789, 4'h9, 8'hA5, 8'h21, 16'h0C06, 2'd1},
    {12'hFFF, 4'hF, 8'h80, 8'h80, 16'h4000, 2'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [PW-1:0] req_page;
  logic [IW-1:0] req_src;
  logic          cmpl_valid;
  logic [PW-1:0] cmpl_page;
  logic [IW-1:0] cmpl_dst;
  logic          tlb_we;
  logic [PW-1:0] tlb_page;
  logic          tlb_lock;
  logic          tlb_priv;
  logic          look_valid;
  logic [PW-1:0] look_page;
  logic [XW-1:0] look_blk;
  logic          look_hit;
  logic          look_dirty;
  logic          mshr_miss_pend;
  logic          mshr_evict_pend;
  logic          wb_valid;
  logic          wb_ready;
  logic          inv_en;

  logic [NB-1:0] m_hit;
  logic [NB-1:0] m_dirty;
  int            pend_left [NB];
  int            wcnt;
  int            wb_wait;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  page_flush_engine #(.PAGE_W(PW), .NODE_W(IW), .BLOCKS(NB)) i_page_flush_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_src(req_src), .cmpl_valid(cmpl_valid),
    .cmpl_page(cmpl_page), .cmpl_dst(cmpl_dst), .tlb_we(tlb_we),
    .tlb_page(tlb_page), .tlb_lock(tlb_lock), .tlb_priv(tlb_priv),
    .look_valid(look_valid), .look_page(look_page), .look_blk(look_blk),
    .look_hit(look_hit), .look_dirty(look_dirty),
    .mshr_miss_pend(mshr_miss_pend), .mshr_evict_pend(mshr_evict_pend),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .inv_en(inv_en)
  );

  // cache / MSHR / writeback model: even blocks report misses, odd ones evictions
  assign look_hit        = m_hit[look_blk];
  assign look_dirty      = m_dirty[look_blk];
  assign mshr_miss_pend  = look_valid && !look_blk[0] && (pend_left[look_blk] > 0);
  assign mshr_evict_pend = look_valid &&  look_blk[0] && (pend_left[look_blk] > 0);
  assign wb_ready        = (wcnt == 0);

  always @(posedge clk) begin
    if (look_valid && look_hit && pend_left[look_blk] > 0)
      pend_left[look_blk] <= pend_left[look_blk] - 1;
    if (wb_valid) begin
      if (wcnt > 0) wcnt <= wcnt - 1;
      else          wcnt <= wb_wait;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req_ready && !look_valid && !wb_valid && !inv_en && !tlb_we && !cmpl_valid,
          req, {req_ready, look_valid, wb_valid, inv_en, tlb_we, cmpl_valid}, 6'b100000);
  endtask

  task automatic run_vec(input logic [49:0] v, input bit poke);
    logic [PW-1:0] pg;
    logic [IW-1:0] sr;
    logic [15:0]   pd;
    int            w;
    int            exp_cyc;
    int            cyc;
    int            last_inv;
    logic [NB-1:0] inv_mask;
    logic [NB-1:0] wb_mask;
    bit            lock_ok, order_ok, pend_ok, pair_ok, hold_ok, poke_ok;
    bit            prev_stall;
    logic [XW-1:0] prev_blk;
    pg = v[49:38]; sr = v[37:34]; pd = v[17:2]; w = int'(v[1:0]);
    m_hit = v[33:26]; m_dirty = v[25:18];
    exp_cyc = 2 + NB;
    for (int b = 0; b < NB; b++) begin
      pend_left[b] = int'((pd >> (2 * b)) & 16'h3);
      if (m_hit[b]) exp_cyc += pend_left[b] + (m_dirty[b] ? w : 0);
    end
    wb_wait = w; wcnt = w;
    @(negedge clk);
    req_valid = 1'b1; req_page = pg; req_src = sr;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0; last_inv = -1; inv_mask = '0; wb_mask = '0;
    lock_ok = 1'b0; order_ok = 1'b1; pend_ok = 1'b1; pair_ok = 1'b1; hold_ok = 1'b1;
    poke_ok = 1'b1; prev_stall = 1'b0; prev_blk = '0;
    forever begin
      cyc++;
      if (cyc == 1)
        lock_ok = tlb_we && tlb_lock && tlb_priv && tlb_page == pg && !look_valid;
      if (poke && cyc >= 3 && cyc <= 5) begin
        if (req_ready) poke_ok = 1'b0;
      end
      if (inv_en) begin
        if (int'(look_blk) <= last_inv) order_ok = 1'b0;
        last_inv = int'(look_blk);
        inv_mask[look_blk] = 1'b1;
        if (look_dirty && !(wb_valid && wb_ready)) pair_ok = 1'b0;
        if (mshr_miss_pend || mshr_evict_pend) pend_ok = 1'b0;
      end
      if (wb_valid && wb_ready) wb_mask[look_blk] = 1'b1;
      if (prev_stall && !(wb_valid && look_blk == prev_blk)) hold_ok = 1'b0;
      prev_stall = wb_valid && !wb_ready;
      prev_blk = look_blk;
      if (cmpl_valid || cyc > 400) break;
      @(negedge clk);
      if (poke && cyc == 2) begin
        req_valid = 1'b1; req_page = 12'h055; req_src = 4'h7;
      end
      if (poke && cyc == 5) req_valid = 1'b0;
    end
    check(lock_ok, "R2 lock write first", {tlb_we, tlb_lock, tlb_priv}, 3'b111);
    check(cyc == exp_cyc, "R3/R7 recovery cycle count", cyc, exp_cyc);
    check(order_ok, "R3 ascending eviction order", last_inv, NB - 1);
    check(inv_mask == m_hit, "R4/R5 evicted set equals present set", inv_mask, m_hit);
    check(wb_mask == (m_hit & m_dirty), "R5/R6 written-back set", wb_mask, m_hit & m_dirty);
    check(pair_ok, "R6 dirty evict with accepted writeback", pair_ok, 1);
    check(pend_ok, "R7 no evict while MSHR pending", pend_ok, 1);
    check(hold_ok, "R10 writeback held until ready", hold_ok, 1);
    check(cmpl_valid && cmpl_page == pg && cmpl_dst == sr, "R8 completion fields",
          {cmpl_valid, cmpl_page, cmpl_dst}, {1'b1, pg, sr});
    check(tlb_we && !tlb_lock && !tlb_priv && tlb_page == pg, "R8 unlock and share",
          {tlb_we, tlb_lock, tlb_priv}, 3'b100);
    if (poke) begin
      check(poke_ok, "R9 ready low while busy", poke_ok, 1);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check(req_ready && !tlb_we && !look_valid, "R9 held-off request ignored",
              {req_ready, tlb_we, look_valid}, 3'b100);
      end
    end else begin
      @(negedge clk);
      check(req_ready, "R8 idle after completion", req_ready, 1);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_page = '0; req_src = '0;
    m_hit = '0; m_dirty = '0; wb_wait = 0; wcnt = 0;
    for (int b = 0; b < NB; b++) pend_left[b] = 0;
    #1;
    check_idle("R1 idle during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after reset");

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    run_vec(VEC[2], 1'b1);

    // reset in the middle of a scan
    @(negedge clk);
    m_hit = '1; m_dirty = '1; wb_wait = 2; wcnt = 2;
    for (int b = 0; b < NB; b++) pend_left[b] = 0;
    req_valid = 1'b1; req_page = 12'h321; req_src = 4'h4;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(look_valid, "R1 scan active before reset", look_valid, 1);
    rst_n = 1'b0;
    #1;
    check_idle("R1 reset aborts scan");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after mid-scan reset");
    run_vec(VEC[1], 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule